// File: doc/BRIEF.md
# Self-Checking Combinational Ring Tester

This block wraps a cascade of combinational test stages in a closed loop, so that test vectors can be produced and checked with no external pattern source. Every stage sends the current n-bit vector through a layer of gates under test, which turns it into an intermediate code word. A decoder layer then turns that code word back into the original vector. A fault-free stage therefore passes its input through unchanged. Any stage can be switched out of the path by its own multiplexer. The vector that leaves the chain is compared against the vector that entered it, which is the content of the ring register.

While the comparison holds, the register loads the chain output plus a programmable step K, modulo 2^n. Over many passes the stages see a wide spread of bit transitions. The first mismatch freezes the register and raises a sticky error flag. Four modes are available: an externally stepped synchronous mode, a free-running mode that emulates self-timed operation, a single-bit loop that toggles only the lowest bit, and a diagnosis mode that holds the ring and reports the first failing stage together with the vectors on either side of it. In this model each gates-under-test layer is a fixed invertible mapping, and a fault input can flip one bit of any stage's code word.

Top module: `cell_ring_tester`

## Requirements
- R1: While rst_n is low, and after it rises, ring_q holds the parameter RESET_VEC (default 4'h3) and err_flag is 0.
- R2: In free-running mode (mode = 1) with no fault, ring_q becomes (ring_q + step_k) mod 2^WIDTH at every clock edge.
- R3: In synchronous mode (mode = 0), ring_q advances by step_k only on edges where step is 1 and holds otherwise.
- R4: In single-bit loop mode (mode = 2) with no fault, only bit 0 of ring_q inverts at each edge, whatever the value of step_k.
- R5: In diagnosis mode (mode = 3), ring_q holds and err_flag is never set.
- R6: When an advance is requested (mode 1 or 2, or mode 0 with step = 1) and the chain output differs from ring_q, err_flag is set at the next edge. From then on ring_q is frozen and err_flag stays 1 until reset.
- R7: In diagnosis mode, diag_hit is 1 exactly when some active stage's output differs from its input. diag_stage is then the lowest such stage index, and diag_in and diag_out are that stage's input and output vectors. Outside diagnosis mode all four diag outputs are 0.
- R8: A stage computes W = rotate-left-by-one(x) XOR a per-stage constant and decodes W by the inverse operation. Setting fault_en flips bit fault_bit of W in stage fault_stage, which inverts stage output bit (fault_bit + WIDTH - 1) mod WIDTH.
- R9: A stage whose bypass bit is 1 passes its input unchanged, so a fault injected into it has no effect on the ring or on the diagnosis outputs.
- R10: The addition wraps modulo 2^WIDTH (for example 4'hE + 4'hF = 4'hD).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 0 synchronous, 1 free-running, 2 single-bit loop, 3 diagnosis |
| step | input | 1 | Advance request used in synchronous mode |
| step_k | input | WIDTH | Increment added to the vector on each pass |
| bypass | input | STAGES | One bit per stage; 1 removes that stage from the path |
| fault_en | input | 1 | Enables code-word bit flip injection |
| fault_stage | input | STG_W | Stage that receives the injected flip |
| fault_bit | input | BIT_W | Code-word bit that is flipped |
| ring_q | output | WIDTH | Ring register, the vector entering the chain |
| err_flag | output | 1 | Sticky functional error |
| diag_hit | output | 1 | A failing stage was found (diagnosis mode) |
| diag_stage | output | STG_W | Index of the first failing stage |
| diag_in | output | WIDTH | Input vector of that stage |
| diag_out | output | WIDTH | Output vector of that stage |

## Verification
The bench injects a flip into a middle stage and checks that diagnosis names that stage and not an earlier or later one. The output it expects differs from the input in exactly the rotated bit position. A design that scanned from the wrong end, or tapped the wrong chain link, would report a wrong index or wrong vectors. The bench also checks that an error latches and that the ring then stays frozen after the fault is removed; a non-sticky flag would let the ring resume. Two further tests catch designs that set an error without an advance request or apply the bypass multiplexer in the wrong place: a fault inside a bypassed stage must leave the ring advancing, and a fault present while synchronous mode is idle must raise no error. Wraparound and the single-bit loop ignoring step_k are checked against a separate model of the arithmetic.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC   = 2'd0,
    MODE_SELF   = 2'd1,
    MODE_SINGLE = 2'd2,
    MODE_DIAG   = 2'd3
  } ring_mode_e;
endpackage

// File: rtl/ring_stage.sv
module ring_stage #(
  parameter int WIDTH = 4,
  parameter int IDX   = 0
) (
  input  logic [WIDTH-1:0] stg_in,
  input  logic             byp,
  input  logic             flip_en,
  input  logic [WIDTH-1:0] flip_mask,
  output logic [WIDTH-1:0] stg_out,
  output logic             bad
);
  localparam int               KEY_I = (IDX * 5 + 3) % (2 ** WIDTH);
  localparam logic [WIDTH-1:0] KEY   = KEY_I[WIDTH-1:0];

  // gates-under-test layer: invertible scramble
  function automatic logic [WIDTH-1:0] gut_layer(input logic [WIDTH-1:0] x);
    return {x[WIDTH-2:0], x[WIDTH-1]} ^ KEY;
  endfunction

  // decoder layer: exact inverse of gut_layer
  function automatic logic [WIDTH-1:0] decode_layer(input logic [WIDTH-1:0] w);
    logic [WIDTH-1:0] v;
    v = w ^ KEY;
    return {v[0], v[WIDTH-1:1]};
  endfunction

  logic [WIDTH-1:0] code_w;
  logic [WIDTH-1:0] rebuilt;

  assign code_w  = gut_layer(stg_in) ^ (flip_en ? flip_mask : '0);
  assign rebuilt = decode_layer(code_w);
  assign stg_out = byp ? stg_in : rebuilt;
  assign bad     = (stg_out != stg_in);
endmodule

// File: rtl/ring_first_fail.sv
module ring_first_fail #(
  parameter int STAGES = 4,
  parameter int STG_W  = 2
) (
  input  logic [STAGES-1:0] bad,
  output logic              hit,
  output logic [STG_W-1:0]  idx
);
  always_comb begin
    idx = '0;
    for (int s = STAGES - 1; s >= 0; s--) begin
      if (bad[s]) idx = STG_W'(s);
    end
  end
  assign hit = |bad;
endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import ring_pkg::*;
#(
  parameter int               WIDTH     = 4,
  parameter logic [WIDTH-1:0] RESET_VEC = 4'h3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ring_mode_e       mode,
  input  logic             step,
  input  logic [WIDTH-1:0] step_k,
  input  logic [WIDTH-1:0] chain_out,
  input  logic             chain_ok,
  output logic [WIDTH-1:0] ring_q,
  output logic             err_flag,
  output logic             adv_req,
  output logic             advance
);
  function automatic logic [WIDTH-1:0] next_vec(input ring_mode_e m,
                                                input logic [WIDTH-1:0] v,
                                                input logic [WIDTH-1:0] k);
    if (m == MODE_SINGLE) return {v[WIDTH-1:1], ~v[0]};
    return v + k;
  endfunction

  assign adv_req = !err_flag &&
                   ((mode == MODE_SELF) || (mode == MODE_SINGLE) ||
                    ((mode == MODE_SYNC) && step));
  assign advance = adv_req && chain_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q   <= RESET_VEC;
      err_flag <= 1'b0;
    end else begin
      if (advance) ring_q <= next_vec(mode, chain_out, step_k);
      if (adv_req && !chain_ok) err_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/cell_ring_tester.sv
module cell_ring_tester
  import ring_pkg::*;
#(
  parameter int               WIDTH     = 4,
  parameter int               STAGES    = 4,
  parameter logic [WIDTH-1:0] RESET_VEC = 4'h3,
  localparam int              STG_W     = (STAGES > 1) ? $clog2(STAGES) : 1,
  localparam int              BIT_W     = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              step,
  input  logic [WIDTH-1:0]  step_k,
  input  logic [STAGES-1:0] bypass,
  input  logic              fault_en,
  input  logic [STG_W-1:0]  fault_stage,
  input  logic [BIT_W-1:0]  fault_bit,
  output logic [WIDTH-1:0]  ring_q,
  output logic              err_flag,
  output logic              diag_hit,
  output logic [STG_W-1:0]  diag_stage,
  output logic [WIDTH-1:0]  diag_in,
  output logic [WIDTH-1:0]  diag_out
);
  ring_mode_e       mode_e;
  logic [WIDTH-1:0] link [STAGES+1];
  logic [STAGES-1:0] stage_bad;
  logic [WIDTH-1:0] flip_mask;
  logic             chain_ok;
  logic             adv_req;
  logic             advance;
  logic             ff_hit;
  logic [STG_W-1:0] ff_idx;
  logic             in_diag;

  assign mode_e    = ring_mode_e'(mode);
  assign flip_mask = WIDTH'(1) << fault_bit;
  assign link[0]   = ring_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    ring_stage #(.WIDTH(WIDTH), .IDX(i)) u_stage (
      .stg_in   (link[i]),
      .byp      (bypass[i]),
      .flip_en  (fault_en && (fault_stage == STG_W'(i))),
      .flip_mask(flip_mask),
      .stg_out  (link[i+1]),
      .bad      (stage_bad[i])
    );
  end

  // comparator: chain output against chain input
  assign chain_ok = (link[STAGES] == ring_q);

  ring_first_fail #(.STAGES(STAGES), .STG_W(STG_W)) u_ff (
    .bad(stage_bad),
    .hit(ff_hit),
    .idx(ff_idx)
  );

  ring_ctrl #(.WIDTH(WIDTH), .RESET_VEC(RESET_VEC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_e),
    .step     (step),
    .step_k   (step_k),
    .chain_out(link[STAGES]),
    .chain_ok (chain_ok),
    .ring_q   (ring_q),
    .err_flag (err_flag),
    .adv_req  (adv_req),
    .advance  (advance)
  );

  assign in_diag    = (mode_e == MODE_DIAG);
  assign diag_hit   = in_diag && ff_hit;
  assign diag_stage = diag_hit ? ff_idx : '0;
  assign diag_in    = diag_hit ? link[ff_idx] : '0;
  assign diag_out   = diag_hit ? link[ff_idx + 1] : '0;
endmodule

// File: rtl/cell_ring_tester_chk.sv
module cell_ring_tester_chk #(
  parameter int WIDTH = 4,
  parameter int STG_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] ring_q,
  input logic             err_flag,
  input logic             diag_hit,
  input logic [STG_W-1:0] diag_stage,
  input logic             adv_req,
  input logic             chain_ok,
  input logic             step
);
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> $stable(ring_q));

  a_r6_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_req && !chain_ok) |=> err_flag);

  a_r5_diag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |=> $stable(ring_q));

  a_r5_diag_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !err_flag) |=> !err_flag);

  a_r3_sync_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !step) |=> $stable(ring_q));

  a_r4_single_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && chain_ok && !err_flag) |=>
      (ring_q[0] != $past(ring_q[0])) && (ring_q[WIDTH-1:1] == $past(ring_q[WIDTH-1:1])));

  a_r7_diag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd3) |-> (!diag_hit && diag_stage == '0));
endmodule

bind cell_ring_tester cell_ring_tester_chk #(.WIDTH(WIDTH), .STG_W(STG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .ring_q    (ring_q),
  .err_flag  (err_flag),
  .diag_hit  (diag_hit),
  .diag_stage(diag_stage),
  .adv_req   (adv_req),
  .chain_ok  (chain_ok),
  .step      (step)
);

// File: tb/test_cell_ring_tester.sv
module test_cell_ring_tester;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       step = 1'b0;
  logic [3:0] step_k = 4'h0;
  logic [3:0] bypass = 4'h0;
  logic       fault_en = 1'b0;
  logic [1:0] fault_stage = 2'd0;
  logic [1:0] fault_bit = 2'd0;
  logic [3:0] ring_q;
  logic       err_flag;
  logic       diag_hit;
  logic [1:0] diag_stage;
  logic [3:0] diag_in;
  logic [3:0] diag_out;

  int tests = 0;
  int fails = 0;
  logic [3:0] exp_q;

  always #5ns clk = ~clk;

  cell_ring_tester i_cell_ring_tester (
    .clk(clk), .rst_n(rst_n), .mode(mode), .step(step), .step_k(step_k),
    .bypass(bypass), .fault_en(fault_en), .fault_stage(fault_stage),
    .fault_bit(fault_bit), .ring_q(ring_q), .err_flag(err_flag),
    .diag_hit(diag_hit), .diag_stage(diag_stage), .diag_in(diag_in),
    .diag_out(diag_out)
  );

  typedef struct packed {
    logic [1:0] md;
    logic       stp;
    logic [3:0] k;
  } row_t;

  // mode, step, step_k
  localparam row_t ROWS [8] = '{
    '{2'd1, 1'b0, 4'h5},   // R2 free-running
    '{2'd1, 1'b0, 4'hB},   // R2
    '{2'd0, 1'b0, 4'h7},   // R3 idle hold
    '{2'd0, 1'b1, 4'h2},   // R3 stepped
    '{2'd2, 1'b0, 4'h7},   // R4 single-bit, step_k ignored
    '{2'd2, 1'b1, 4'h9},   // R4
    '{2'd3, 1'b1, 4'h1},   // R5 diagnosis hold
    '{2'd1, 1'b0, 4'hF}    // R2
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] model_next(input logic [1:0] md, input logic stp,
                                            input logic [3:0] q, input logic [3:0] k);
    case (md)
      2'd1:    return 4'((q + k) & 4'hF);
      2'd0:    return stp ? 4'(q + k) : q;
      2'd2:    return q ^ 4'b0001;
      default: return q;
    endcase
  endfunction

  initial begin
    #(200000 * 10ns);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ring_q", ring_q, 4'h3);
    check("R1 reset err", err_flag, 0);
    rst_n = 1'b1;
    tick();
    check("R1 after release", ring_q, 4'h3);
    exp_q = 4'h3;

    for (int r = 0; r < 8; r++) begin
      mode = ROWS[r].md; step = ROWS[r].stp; step_k = ROWS[r].k;
      tick();
      exp_q = model_next(ROWS[r].md, ROWS[r].stp, exp_q, ROWS[r].k);
      check($sformatf("R2/R3/R4/R5 table row %0d", r), ring_q, exp_q);
      check("R5/R6 no error in table", err_flag, 0);
    end

    // R10 wraparound: drive ring to E then add F
    mode = 2'd1; step_k = 4'(4'hE - exp_q);
    tick();
    check("R10 setup", ring_q, 4'hE);
    step_k = 4'hF;
    tick();
    check("R10 wrap", ring_q, 4'hD);
    exp_q = 4'hD;

    // fault present while synchronous mode idle: no error, diag quiet (R7)
    mode = 2'd0; step = 1'b0;
    fault_en = 1'b1; fault_stage = 2'd2; fault_bit = 2'd1;
    #1ns;
    check("R7 diag quiet outside diag", {diag_hit, diag_stage, diag_in, diag_out}, 0);
    tick();
    check("R6 no request no error", err_flag, 0);
    check("R3 idle hold with fault", ring_q, exp_q);

    // diagnosis of stage 2, W bit 1 -> output bit 0 inverted (R8, R7)
    mode = 2'd3;
    #1ns;
    check("R7 diag_hit", diag_hit, 1);
    check("R7 diag_stage", diag_stage, 2);
    check("R7 diag_in", diag_in, exp_q);
    check("R8 diag_out bit flip", diag_out, exp_q ^ 4'b0001);
    tick();
    check("R5 diag no err", err_flag, 0);
    check("R5 diag hold", ring_q, exp_q);

    // R9 fault inside bypassed stage is harmless
    bypass = 4'b0010; fault_stage = 2'd1; fault_bit = 2'd3;
    #1ns;
    check("R9 diag sees nothing", diag_hit, 0);
    mode = 2'd1; step_k = 4'h4;
    tick();
    exp_q = 4'(exp_q + 4'h4);
    check("R9 ring advances", ring_q, exp_q);
    check("R9 no error", err_flag, 0);

    // R6 fault in active stage 3, W bit 0 -> output bit 3
    bypass = 4'b0000; fault_stage = 2'd3; fault_bit = 2'd0;
    mode = 2'd3;
    #1ns;
    check("R8 stage3 diag_out", diag_out, exp_q ^ 4'b1000);
    check("R7 stage3 index", diag_stage, 3);
    mode = 2'd1;
    tick();
    check("R6 err set", err_flag, 1);
    check("R6 ring frozen", ring_q, exp_q);
    fault_en = 1'b0;
    repeat (3) tick();
    check("R6 err sticky", err_flag, 1);
    check("R6 ring stays frozen", ring_q, exp_q);

    // reset clears the error (R1)
    rst_n = 1'b0;
    tick();
    check("R1 reset clears err", err_flag, 0);
    check("R1 reset vector", ring_q, 4'h3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule